// File: doc/BRIEF.md
# Stereo Audio Serial Port (Multi-Format Slave)

This block is the digital serial port of a stereo converter pair. It runs as a slave: the bit clock and the frame (word-select) clock come from outside, and both are oversampled by a fast system clock. On the capture side it serialises a 24-bit left/right sample pair onto `sd_out`. On the playback side it deserialises a left/right pair from `sd_in` and hands the pair to the core as parallel words with a one-cycle strobe.

A 3-bit format input picks one of five framings. The capture direction is always 24-bit MSB-justified or I2S. The playback direction in the same setting may be 16-, 20- or 24-bit LSB-justified, 24-bit MSB-justified or I2S. Data is two's complement, sent MSB first. The capture pair is latched once per frame, at the start of the left channel, and `cap_take` tells the core when that happened. Clearing `adc_run` forces the serial output low while the converter is held in reset or power-down.

Top module: `audio_serial_port`

## Requirements
- R1: While `rst_n` is low, `sd_out`, `cap_take` and `pb_valid` are 0 and both playback words are zero.
- R2: In formats 0, 1, 2 and 4 (`fmt_sel` = 3'b000, 3'b001, 3'b010, 3'b100) the capture side is MSB-justified. Frame clock high is the left channel. Bit 23 of the word goes out on the first bit clock of the half-frame, followed by the lower bits in turn. `sd_out` changes only after a falling bit-clock edge.
- R3: In format 3 (3'b011) both directions are I2S. Frame clock low is the left channel, and the MSB sits one bit clock after the frame-clock edge. When a half-frame is 24 bits long, the LSB falls on the first bit clock of the following half-frame.
- R4: Capture bits past the 24th of a half-frame are 0. A half-frame shorter than 24 bits (format 0 at 32 bit clocks per frame) carries only the MSBs that fit.
- R5: In format 2 playback is 24-bit MSB-justified. Bits after the 24th of a half-frame have no effect on the received words.
- R6: In formats 0, 1 and 4 playback is LSB-justified with 16, 20 and 24 bits. The sample's LSB is the last bit clock of the half-frame, the leading bits have no effect, and the sample is sign-extended to 24 bits.
- R7: The capture pair is taken from `cap_left`/`cap_right` at the start of each left half-frame (one bit clock later in I2S). `cap_take` pulses for one cycle each time this happens.
- R8: `pb_valid` pulses for one cycle once per frame, after the right half-frame completes. It presents the left and right words of that same frame, and both words hold their value between pulses.
- R9: While `adc_run` is low, `sd_out` is 0 from the next clock cycle on.
- R10: Every format works with any half-frame length from the format's minimum (16, 20 or 24 bits) up to 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 3 | Frame format select, 0 to 4 |
| adc_run | input | 1 | Capture path running; low forces `sd_out` low |
| bck_in | input | 1 | External bit clock |
| lrck_in | input | 1 | External frame clock (channel select) |
| sd_in | input | 1 | Serial playback data |
| cap_left | input | SAMPLE_W | Left capture sample from the core |
| cap_right | input | SAMPLE_W | Right capture sample from the core |
| cap_take | output | 1 | One-cycle pulse when the capture pair is latched |
| sd_out | output | 1 | Serial capture data |
| pb_left | output | SAMPLE_W | Received left playback sample |
| pb_right | output | SAMPLE_W | Received right playback sample |
| pb_valid | output | 1 | One-cycle strobe for a new playback pair |

## Verification
The assertions assume that the frame clock and `sd_in` change only together with a falling bit-clock edge. They also assume that each bit-clock phase spans several system clocks, so that two bit-clock edges never land in the same synchronised cycle, and that `fmt_sel` stays fixed outside reset. The stimulus drives the serial lines only on falling bit-clock edges, holds each bit-clock phase for eight system clocks, and changes the format only while reset is held. It also changes the capture words only in the middle of a right half-frame, well away from the cycle in which they are latched.

// File: rtl/asp_pkg.sv
package asp_pkg;

    typedef enum logic [2:0] {
        FMT_LSB16 = 3'd0,
        FMT_LSB20 = 3'd1,
        FMT_MSB24 = 3'd2,
        FMT_I2S   = 3'd3,
        FMT_LSB24 = 3'd4
    } asp_fmt_e;

    // I2S framing is the justified framing seen one bit clock late
    function automatic logic fmt_is_i2s(logic [2:0] f);
        return f == FMT_I2S;
    endfunction

    function automatic logic fmt_is_lsb(logic [2:0] f);
        return (f == FMT_LSB16) || (f == FMT_LSB20) || (f == FMT_LSB24);
    endfunction

    // Playback sample width for the right-aligned formats
    function automatic int fmt_lsb_bits(logic [2:0] f, int full_w);
        case (f)
            FMT_LSB16: return 16;
            FMT_LSB20: return 20;
            default:   return full_w;
        endcase
    endfunction

endpackage

// File: rtl/asp_edge.sv
module asp_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bck,
    input  logic lrck,
    input  logic sd,
    output logic rise,
    output logic fall,
    output logic lr_s,
    output logic sd_s
);
    localparam int NSIG = 3;

    typedef struct packed {
        logic [NSIG-1:0][STAGES-1:0] chain;
        logic                        bk_last;
    } sync_t;

    sync_t q, d;
    logic [NSIG-1:0] raw;

    assign raw = {sd, lrck, bck};

    always_comb begin
        d = q;
        for (int s = 0; s < NSIG; s++) begin
            d.chain[s] = (q.chain[s] << 1) | STAGES'(raw[s]);
        end
        d.bk_last = q.chain[0][STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // All three lines pass through equal depth, so lr_s and sd_s belong
    // to the same sampling instant as the detected bit-clock edge.
    assign rise = q.chain[0][STAGES-1] & ~q.bk_last;
    assign fall = ~q.chain[0][STAGES-1] & q.bk_last;
    assign lr_s = q.chain[1][STAGES-1];
    assign sd_s = q.chain[2][STAGES-1];

endmodule

// File: rtl/asp_tx.sv
module asp_tx
    import asp_pkg::*;
#(
    parameter int W        = 24,
    parameter int MAX_HALF = 32,
    localparam int CW      = $clog2(MAX_HALF + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fall,
    input  logic         lr,
    input  logic [2:0]   fmt,
    input  logic         en,
    input  logic [W-1:0] cap_l,
    input  logic [W-1:0] cap_r,
    output logic         sd,
    output logic         take
);
    localparam logic [CW-1:0] IDX_TOP = CW'(MAX_HALF);

    typedef struct packed {
        logic          primed;
        logic          lr_del;
        logic          eff_last;
        logic [CW-1:0] idx;
        logic [W-1:0]  hold_l;
        logic [W-1:0]  hold_r;
        logic          sd;
        logic          take;
    } tx_t;

    tx_t q, d;
    logic         i2s, left_lvl, eff;
    logic [W-1:0] word, shifted;
    int           pos;

    always_comb begin
        d        = q;
        d.take   = 1'b0;
        i2s      = fmt_is_i2s(fmt);
        left_lvl = ~i2s;
        eff      = i2s ? q.lr_del : lr;
        word     = '0;
        shifted  = '0;
        pos      = 0;
        if (fall) begin
            d.lr_del = lr;
            if (!q.primed) begin
                d.primed   = 1'b1;
                d.eff_last = eff;
                d.idx      = IDX_TOP;
            end else if (eff != q.eff_last) begin
                d.eff_last = eff;
                d.idx      = '0;
                if (eff == left_lvl) begin
                    d.hold_l = cap_l;
                    d.hold_r = cap_r;
                    d.take   = 1'b1;
                end
            end else if (q.idx != IDX_TOP) begin
                d.idx = q.idx + 1'b1;
            end
            word    = (d.eff_last == left_lvl) ? d.hold_l : d.hold_r;
            pos     = int'(d.idx);
            shifted = word << pos;
            d.sd    = (pos < W) ? shifted[W-1] : 1'b0;
        end
        if (!en) d.sd = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sd   = q.sd;
    assign take = q.take;

endmodule

// File: rtl/asp_rx.sv
module asp_rx
    import asp_pkg::*;
#(
    parameter int W        = 24,
    parameter int MAX_HALF = 32,
    localparam int CW      = $clog2(MAX_HALF + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rise,
    input  logic         lr,
    input  logic         sd,
    input  logic [2:0]   fmt,
    output logic [W-1:0] pb_l,
    output logic [W-1:0] pb_r,
    output logic         valid
);
    localparam logic [CW-1:0] IDX_TOP = CW'(MAX_HALF);

    typedef struct packed {
        logic          primed;
        logic          lr_del;
        logic          eff_last;
        logic          seen;
        logic          left_ok;
        logic [CW-1:0] idx;
        logic [W-1:0]  shreg;
        logic [W-1:0]  pend_l;
        logic [W-1:0]  pb_l;
        logic [W-1:0]  pb_r;
        logic          valid;
    } rx_t;

    rx_t q, d;
    logic         i2s, lsb, left_lvl, eff, sgn;
    logic [W-1:0] mask, top, done;
    int           nb;

    // Word finished in the previous half-frame, aligned and extended
    always_comb begin
        lsb  = fmt_is_lsb(fmt);
        nb   = fmt_lsb_bits(fmt, W);
        mask = (W'(1) << nb) - W'(1);
        top  = q.shreg >> (nb - 1);
        sgn  = top[0];
        if (lsb) done = (q.shreg & mask) | (sgn ? ~mask : '0);
        else     done = q.shreg;
    end

    always_comb begin
        d        = q;
        d.valid  = 1'b0;
        i2s      = fmt_is_i2s(fmt);
        left_lvl = ~i2s;
        eff      = i2s ? q.lr_del : lr;
        if (rise) begin
            d.lr_del = lr;
            if (!q.primed) begin
                d.primed   = 1'b1;
                d.eff_last = eff;
                d.idx      = IDX_TOP;
            end else begin
                if (eff != q.eff_last) begin
                    if (q.seen) begin
                        if (q.eff_last == left_lvl) begin
                            d.pend_l  = done;
                            d.left_ok = 1'b1;
                        end else if (q.left_ok) begin
                            d.pb_l    = q.pend_l;
                            d.pb_r    = done;
                            d.valid   = 1'b1;
                            d.left_ok = 1'b0;
                        end
                    end
                    d.seen     = 1'b1;
                    d.eff_last = eff;
                    d.idx      = '0;
                end else if (q.idx != IDX_TOP) begin
                    d.idx = q.idx + 1'b1;
                end
                if (lsb || (int'(d.idx) < W)) begin
                    d.shreg = {q.shreg[W-2:0], sd};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pb_l  = q.pb_l;
    assign pb_r  = q.pb_r;
    assign valid = q.valid;

endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port #(
    parameter int SAMPLE_W    = 24,
    parameter int MAX_HALF    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          fmt_sel,
    input  logic                adc_run,
    input  logic                bck_in,
    input  logic                lrck_in,
    input  logic                sd_in,
    input  logic [SAMPLE_W-1:0] cap_left,
    input  logic [SAMPLE_W-1:0] cap_right,
    output logic                cap_take,
    output logic                sd_out,
    output logic [SAMPLE_W-1:0] pb_left,
    output logic [SAMPLE_W-1:0] pb_right,
    output logic                pb_valid
);
    logic bck_rise, bck_fall, lr_s, sd_s;

    asp_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .bck  (bck_in),
        .lrck (lrck_in),
        .sd   (sd_in),
        .rise (bck_rise),
        .fall (bck_fall),
        .lr_s (lr_s),
        .sd_s (sd_s)
    );

    asp_tx #(.W(SAMPLE_W), .MAX_HALF(MAX_HALF)) u_tx (
        .clk  (clk),
        .rst_n(rst_n),
        .fall (bck_fall),
        .lr   (lr_s),
        .fmt  (fmt_sel),
        .en   (adc_run),
        .cap_l(cap_left),
        .cap_r(cap_right),
        .sd   (sd_out),
        .take (cap_take)
    );

    asp_rx #(.W(SAMPLE_W), .MAX_HALF(MAX_HALF)) u_rx (
        .clk  (clk),
        .rst_n(rst_n),
        .rise (bck_rise),
        .lr   (lr_s),
        .sd   (sd_s),
        .fmt  (fmt_sel),
        .pb_l (pb_left),
        .pb_r (pb_right),
        .valid(pb_valid)
    );

endmodule

// File: rtl/audio_serial_port_chk.sv
module audio_serial_port_chk #(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic         adc_run,
    input logic         sd_out,
    input logic         bck_rise,
    input logic         bck_fall,
    input logic         pb_valid,
    input logic [W-1:0] pb_left,
    input logic         cap_take
);
    assert_sd_low_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_run |=> !sd_out);

    assert_sd_moves_after_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_out != $past(sd_out)) |-> ($past(bck_fall) || !$past(adc_run)));

    assert_take_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_take |=> !cap_take);

    assert_take_after_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_take |-> $past(bck_fall));

    assert_pair_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pb_valid |=> !pb_valid);

    assert_pair_after_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pb_valid |-> $past(bck_rise));

    assert_pair_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_left != $past(pb_left)) |-> pb_valid);

endmodule

bind audio_serial_port audio_serial_port_chk #(.W(SAMPLE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .adc_run (adc_run),
    .sd_out  (sd_out),
    .bck_rise(bck_rise),
    .bck_fall(bck_fall),
    .pb_valid(pb_valid),
    .pb_left (pb_left),
    .cap_take(cap_take)
);

// File: tb/audio_serial_port_test.sv
module audio_serial_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 24;
    localparam int HB         = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   fmt_sel = 3'd2;
    logic         adc_run = 1'b1;
    logic         bck = 1'b1;
    logic         lrck = 1'b0;
    logic         sd_in = 1'b0;
    logic [W-1:0] cap_left = '0;
    logic [W-1:0] cap_right = '0;
    logic         cap_take, sd_out, pb_valid;
    logic [W-1:0] pb_left, pb_right;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_serial_port uut (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .adc_run(adc_run),
        .bck_in(bck), .lrck_in(lrck), .sd_in(sd_in),
        .cap_left(cap_left), .cap_right(cap_right), .cap_take(cap_take),
        .sd_out(sd_out), .pb_left(pb_left), .pb_right(pb_right), .pb_valid(pb_valid)
    );

    int             checks = 0, errors = 0, takes = 0;
    logic [2*W-1:0] exp_q[$];
    logic [2*W-1:0] popped;
    string          rx_tag = "R8";
    logic [W-1:0]   prev_pb = '0, prev_cp = '0;
    bit             first = 1'b1, finished = 1'b0;

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int lsb_n(logic [2:0] f);
        case (f)
            3'd0: return 16;
            3'd1: return 20;
            3'd4: return 24;
            default: return 0;
        endcase
    endfunction

    function automatic logic bit_of(logic [W-1:0] w, int k);
        logic [W-1:0] t;
        t = w >> k;
        return t[0];
    endfunction

    function automatic logic [W-1:0] ext(logic [W-1:0] w, int n);
        logic [W-1:0] m;
        if (n == 0 || n >= W) return w;
        m = (W'(1) << n) - W'(1);
        return bit_of(w, n - 1) ? (w | ~m) : (w & m);
    endfunction

    // Playback bit at raw index i of a half-frame (fill bits are 1)
    function automatic logic send_bit(int b, logic [W-1:0] cur, logic [W-1:0] prv, int i);
        int e, n;
        logic [W-1:0] w;
        w = cur; e = i;
        if (fmt_sel == 3'd3) begin
            if (i == 0) begin w = prv; e = b - 1; end
            else e = i - 1;
        end
        n = lsb_n(fmt_sel);
        if (n == 0) return (e < W) ? bit_of(w, W - 1 - e) : 1'b1;
        return (e >= b - n) ? bit_of(w, b - 1 - e) : 1'b1;
    endfunction

    // Expected capture bit at raw index i of a half-frame
    function automatic logic out_bit(int b, logic [W-1:0] cur, logic [W-1:0] prv, int i, bit on);
        int e;
        logic [W-1:0] w;
        if (!on) return 1'b0;
        w = cur; e = i;
        if (fmt_sel == 3'd3) begin
            if (i == 0) begin w = prv; e = b - 1; end
            else e = i - 1;
        end
        return (e < W) ? bit_of(w, W - 1 - e) : 1'b0;
    endfunction

    // Monitor: pops the scoreboard on every playback strobe
    always @(negedge clk) begin
        if (rst_n) begin
            if (cap_take) takes++;
            if (pb_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected playback pair", 64'({pb_left, pb_right}), 64'(0));
                end else begin
                    popped = exp_q.pop_front();
                    check({pb_left, pb_right} == popped, rx_tag, "playback pair",
                          64'({pb_left, pb_right}), 64'(popped));
                end
            end
        end
    end

    task automatic drive_half(bit is_left, int b, logic [W-1:0] pcur, logic [W-1:0] pprv,
                              logic [W-1:0] ccur, logic [W-1:0] cprv, bit chk, bit on,
                              bit skip0, bit upd, string tag);
        int bad = 0;
        logic [63:0] got = '0, want = '0;
        logic eb;
        for (int i = 0; i < b; i++) begin
            @(negedge clk);
            bck = 1'b0;
            if (i == 0) lrck = is_left ^ (fmt_sel == 3'd3);
            sd_in = send_bit(b, pcur, pprv, i);
            if (upd && i == b / 2) begin
                cap_left  = W'($urandom);
                cap_right = W'($urandom);
            end
            repeat (HB) @(negedge clk);
            eb   = out_bit(b, ccur, cprv, i, on);
            got  = got | (64'(sd_out) << i);
            want = want | (64'(eb) << i);
            if (chk && !(skip0 && i == 0) && sd_out !== eb) bad++;
            bck = 1'b1;
            repeat (HB - 1) @(negedge clk);
        end
        if (chk) check(bad == 0, tag, is_left ? "serial left half" : "serial right half", got, want);
    endtask

    task automatic run_frame(int b, bit on, string tag);
        logic [W-1:0] pl, pr, cl, cr;
        pl = W'($urandom); pr = W'($urandom);
        cl = cap_left;     cr = cap_right;
        adc_run = on;
        drive_half(1'b1, b, pl, prev_pb, cl, prev_cp, 1'b1, on, first && fmt_sel == 3'd3, 1'b0, tag);
        drive_half(1'b0, b, pr, pl, cr, cl, 1'b1, on, 1'b0, 1'b1, tag);
        exp_q.push_back({ext(pl, lsb_n(fmt_sel)), ext(pr, lsb_n(fmt_sel))});
        prev_pb = pr; prev_cp = cr; first = 1'b0;
    endtask

    task automatic run_section(logic [2:0] f, int b, int frames, int off_idx,
                               string txtag, string rxtag);
        @(negedge clk);
        rst_n = 1'b0; fmt_sel = f; adc_run = 1'b1; bck = 1'b1; sd_in = 1'b0;
        lrck = (f == 3'd3);
        cap_left = W'($urandom); cap_right = W'($urandom);
        repeat (5) @(negedge clk);
        // R1: reset values
        check(sd_out == 1'b0 && pb_valid == 1'b0 && cap_take == 1'b0 && pb_left == '0 && pb_right == '0,
              "R1", "reset outputs", 64'({sd_out, pb_valid, cap_take, pb_left}), 64'(0));
        exp_q.delete(); takes = 0; prev_pb = '0; prev_cp = '0; first = 1'b1; rx_tag = rxtag;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        drive_half(1'b0, 4, '0, '0, '0, '0, 1'b0, 1'b1, 1'b0, 1'b0, txtag);
        for (int k = 0; k < frames; k++) run_frame(b, k != off_idx, txtag);
        adc_run = 1'b1;
        drive_half(1'b1, b, '0, prev_pb, cap_left, prev_cp, 1'b0, 1'b1, 1'b0, 1'b0, txtag);
        repeat (4 * HB) @(negedge clk);
        check(exp_q.size() == 0, "R8", "pairs still outstanding", 64'(exp_q.size()), 64'(0));
        check(takes == frames + 1, "R7", "capture loads", 64'(takes), 64'(frames + 1));
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        run_section(3'd2, 32, 4, 2,  "R2/R4/R9/R10", "R5/R8");
        run_section(3'd2, 24, 2, -1, "R2/R10",       "R5/R8/R10");
        run_section(3'd3, 32, 3, -1, "R3",           "R3/R8");
        run_section(3'd3, 24, 3, -1, "R3/R10",       "R3/R8/R10");
        run_section(3'd0, 16, 3, -1, "R4/R10",       "R6/R8/R10");
        run_section(3'd0, 32, 2, -1, "R2/R4",        "R6");
        run_section(3'd1, 20, 2, -1, "R4/R10",       "R6/R10");
        run_section(3'd4, 24, 2, -1, "R2",           "R6");
        run_section(3'd4, 32, 2, -1, "R2/R4",        "R6");
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule